// File: doc/BRIEF.md
# Polyphase Non-Recursive CIC Decimator

This block is the first rate-reduction stage placed right after a sigma-delta modulator. It accepts a narrow signed sample stream at the oversampled rate and produces one full-precision word for every 64 accepted samples. Its overall response is a 64-tap moving sum raised to the fourth power. No integrator feedback loops are used.

The response is split into six identical halving sections. Each section has the transfer function (1+z^-1)^4 and drops every other sample. Each section holds a four-deep history of its own input. It forms a result only on the second sample of each pair, so its arithmetic runs at the section's output rate. The even-phase taps (1, 6, 1) and the odd-phase taps (4, 4) are built from fixed shifts and adds, with no multiplier and no stored coefficient. Each section widens its word by 4 bits, so a 4-bit input becomes a 28-bit result that can never overflow. Output words whose impulse-response window still reaches back before reset are held back.

Top module: `cic_poly_dec`

## Requirements
- R1: While reset is high at a clock edge, that edge clears all section history, phase state and the priming counter. In the cycle after reset, out_valid is 0 and out_data is 0. A run started after reset gives the same outputs as a run from power-up, even if reset interrupts a stream.
- R2: Count accepted samples (cycles with in_valid high) from 0 after reset. A result is produced once for every 64 accepted samples, after sample 64j+63 has been accepted, with j = 0, 1, 2 and so on.
- R3: Result j equals the sum, over k = 0 to 252, of c[k]·x[64j+63−k], where x is the accepted samples read as 4-bit two's complement, x before reset counts as zero, and c is the 64-tap all-ones window convolved with itself four times. The result is exact in 28-bit two's complement: a constant input of −8 yields −134217728 and a constant input of +7 yields 117440512.
- R4: Results j = 0, 1 and 2 after reset are not strobed. The first out_valid pulse after reset carries result j = 3, and later pulses carry j = 4, 5 and so on in order.
- R5: A sample is taken only in cycles with in_valid high. The value on in_data in other cycles has no effect on any result, and idle cycles between samples do not change the results.
- R6: out_valid is high for exactly one cycle per result. out_data changes only in a cycle where out_valid is high and holds its value until the next pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_data in this cycle |
| in_data | input | 4 | Signed two's-complement modulator sample |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | 28 | Signed full-precision decimated result |

## Verification
The rate and priming checks assume that in_valid is never high while reset is high. They also assume the stream is shorter than the range of the checker's 32-bit sample counter, so every accepted sample is counted. The bench only raises in_valid between resets and keeps each run to a few hundred samples. In idle cycles it puts changing values on in_data, so that a result matching the model shows those values were ignored. The stimulus includes full-scale constants of both signs at the 28-bit limits, an impulse that shows the kernel shape, and a reset in the middle of a stream.

// File: rtl/cic_poly_dec.sv
module cic_poly_dec #(
  parameter int IN_W   = 4,
  parameter int STAGES = 6
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  input  logic signed [IN_W-1:0]           in_data,
  output logic                             out_valid,
  output logic signed [IN_W+4*STAGES-1:0]  out_data
);
  localparam int OUT_W = IN_W + 4 * STAGES;
  localparam int SKIP  = (STAGES >= 2) ? 3 : 2;
  localparam int SKW   = $clog2(SKIP + 1);

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    localparam int WI = IN_W + 4 * s;
    localparam int WO = WI + 4;

    logic signed [WI-1:0] xin, h1, h2, h3, h4;
    logic signed [WO-1:0] even_sum, odd_sum, y;
    logic vin, ph, vo;

    if (s == 0) begin : g_in
      assign xin = in_data;
      assign vin = in_valid;
    end else begin : g_in
      assign xin = g_st[s-1].y;
      assign vin = g_st[s-1].vo;
    end

    assign even_sum = WO'(xin) + (WO'(h2) <<< 2) + (WO'(h2) <<< 1) + WO'(h4);
    assign odd_sum  = (WO'(h1) <<< 2) + (WO'(h3) <<< 2);

    always_ff @(posedge clk) begin
      if (rst) begin
        h1 <= '0;
        h2 <= '0;
        h3 <= '0;
        h4 <= '0;
        ph <= 1'b0;
        vo <= 1'b0;
        y  <= '0;
      end else begin
        vo <= 1'b0;
        if (vin) begin
          h1 <= xin;
          h2 <= h1;
          h3 <= h2;
          h4 <= h3;
          ph <= ~ph;
          if (ph) begin
            y  <= even_sum + odd_sum;
            vo <= 1'b1;
          end
        end
      end
    end
  end

  logic [SKW-1:0] prime_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prime_cnt <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (g_st[STAGES-1].vo) begin
        if (prime_cnt == SKW'(SKIP)) begin
          out_valid <= 1'b1;
          out_data  <= g_st[STAGES-1].y;
        end else begin
          prime_cnt <= prime_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cic_poly_dec_chk.sv
module cic_poly_dec_chk #(
  parameter int OUT_W = 28,
  parameter int DEC   = 64,
  parameter int SKIP  = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_data
);
  int unsigned acc_cnt, out_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_cnt <= 0;
      out_cnt <= 0;
    end else begin
      if (in_valid)  acc_cnt <= acc_cnt + 1;
      if (out_valid) out_cnt <= out_cnt + 1;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == '0));

  // R2 and R4: a strobe never comes before its group (primed index) is complete
  assert_primed_rate_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (acc_cnt >= DEC * (out_cnt + SKIP + 1)));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_hold_between_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(out_data)) |-> out_valid);
endmodule

bind cic_poly_dec cic_poly_dec_chk #(
  .OUT_W(OUT_W), .DEC(2 ** STAGES), .SKIP(SKIP)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/cic_poly_dec_bench.sv
`timescale 1ns/1ps
module cic_poly_dec_bench;
  localparam int IN_W = 4;
  localparam int STAGES = 6;
  localparam int OUT_W = IN_W + 4 * STAGES;
  localparam int DEC = 64;
  localparam int KLEN = 4 * (DEC - 1) + 1;
  localparam int SKIP = 3;
  localparam int NSEG = 8;
  localparam int SEGLEN = 640;

  // mode: 0 const, 1 alternate val/-val-1, 2 ramp, 3 pseudo-random, 4 impulse
  localparam int MODE [NSEG] = '{0, 0, 1, 2, 3, 3, 4, 0};
  localparam int VAL  [NSEG] = '{7, -8, 7, 0, 0, 0, 7, -8};
  localparam int GAP  [NSEG] = '{0, 0, 0, 0, 0, 2, 0, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_data = '0;
  logic out_valid;
  logic signed [OUT_W-1:0] out_data;

  cic_poly_dec #(.IN_W(IN_W), .STAGES(STAGES)) u_cic_poly_dec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  longint coef [KLEN];
  int xs [2048];
  int nin = 0;
  int nout = 0;
  longint last_exp = 0;

  function automatic int gen(int mode, int val, int n);
    int r;
    case (mode)
      0: return val;
      1: return (n % 2 == 0) ? val : -val - 1;
      2: return (n % 16) - 8;
      3: begin r = (n * 1103515245 + 12345) >>> 16; return (r & 15) - 8; end
      default: return (n == 300) ? val : 0;
    endcase
  endfunction

  function automatic longint model(int j);
    longint acc = 0;
    int base = DEC * j + DEC - 1;
    for (int k = 0; k < KLEN; k++)
      if (base - k >= 0) acc += coef[k] * longint'(xs[base - k]);
    return acc;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst) nout = 0;
    else if (out_valid) begin
      last_exp = model(nout + SKIP);
      check(longint'(out_data) == last_exp, "R3", longint'(out_data), last_exp);
      nout++;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nin = 0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R1", longint'(out_data), 0);
  endtask

  task automatic send(int v, int gap);
    in_valid = 1'b1;
    in_data = IN_W'(v);
    xs[nin] = v;
    nin++;
    @(negedge clk);
    for (int g = 0; g < gap; g++) begin
      in_valid = 1'b0;
      in_data = IN_W'(g % 2 == 0 ? 7 : -8);
      @(negedge clk);
    end
  endtask

  task automatic finish_seg(int groups, string tag);
    in_valid = 1'b0;
    repeat (12) @(negedge clk);
    check(nout == groups - SKIP, tag, nout, groups - SKIP);
    check(!out_valid && longint'(out_data) == last_exp, "R6", longint'(out_data), last_exp);
  endtask

  initial begin
    longint tmp [KLEN];
    for (int n = 0; n < KLEN; n++) coef[n] = (n == 0) ? 1 : 0;
    for (int r = 0; r < 4; r++) begin
      for (int n = 0; n < KLEN; n++) begin
        tmp[n] = 0;
        for (int k = 0; k < DEC; k++) if (n - k >= 0) tmp[n] += coef[n - k];
      end
      for (int n = 0; n < KLEN; n++) coef[n] = tmp[n];
    end

    for (int e = 0; e < NSEG; e++) begin
      do_reset();
      for (int n = 0; n < SEGLEN; n++) send(gen(MODE[e], VAL[e], n), GAP[e]);
      finish_seg(SEGLEN / DEC, (GAP[e] != 0) ? "R5" : "R2");
      if (MODE[e] == 0 && VAL[e] == -8)
        check(last_exp == -134217728, "R3", last_exp, -134217728);
      if (MODE[e] == 0 && VAL[e] == 7)
        check(last_exp == 117440512, "R3", last_exp, 117440512);
    end

    // R4: fewer than four groups give no strobe at all
    do_reset();
    for (int n = 0; n < 4 * DEC - 1; n++) send(-8, 0);
    in_valid = 1'b0;
    repeat (12) @(negedge clk);
    check(nout == 0, "R4", nout, 0);
    send(-8, 0);
    repeat (12) @(negedge clk);
    check(nout == 1, "R4", nout, 1);
    check(longint'(out_data) == -134217728, "R4", longint'(out_data), -134217728);

    // R1: reset in mid-stream leaves no trace of earlier samples
    do_reset();
    for (int n = 0; n < 100; n++) send(7, 0);
    do_reset();
    for (int n = 0; n < 4 * DEC; n++) send(gen(3, 0, n), 0);
    finish_seg(4, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule